// File: doc/BRIEF.md
# Load/Store Lane and Block-Transfer Unit

This unit sits between an execute stage and a simple byte-addressed 32-bit memory port. The port returns read data combinationally. For a single access it steers data between the memory word and the register side. A load takes a byte, a halfword or the whole word out of the read data and widens it to 32 bits, filling the upper bits with zeros or with copies of the sign bit. A store moves the low byte or the low halfword of the source value into the addressed lane and raises the matching byte enables. Words pass through unchanged. Byte ordering is little-endian.

The unit also runs block transfers. Given a base address and a 16-bit register mask, it reads a run of consecutive words into registers or writes a run of registers out to consecutive words, one word per cycle. A small state machine runs the block transfer. It has three states: `SEQ_IDLE`, `SEQ_XFER` and `SEQ_DONE`. The transitions are:

- IDLE→XFER: start is accepted and the mask is non-empty.
- IDLE→DONE: start is accepted and the mask is empty.
- XFER→XFER: more mask bits remain.
- XFER→DONE: the last set bit has just been served.
- DONE→IDLE: always, after one cycle.

While a block transfer owns the port, single accesses are held off.

Top module: `ldst_lane_unit`

## Requirements
- R1: An unsigned byte load (`acc_size`=2'b00, `acc_signed`=0) returns the byte selected by `acc_addr[1:0]` in `ld_data[7:0]` with zeros above it. Lane 0 is `mem_rdata[7:0]` and lane 3 is `mem_rdata[31:24]`.
- R2: An unsigned halfword load (`acc_size`=2'b01) returns `mem_rdata[15:0]` when `acc_addr[1]`=0 and `mem_rdata[31:16]` when it is 1, in `ld_data[15:0]`, with zeros above it.
- R3: With `acc_signed`=1, byte and halfword loads fill every bit of `ld_data` above the loaded value with that value's top bit.
- R4: A byte store drives `mem_be` = 1 << `acc_addr[1:0]` and places `acc_wdata[7:0]` in the selected lane of `mem_wdata`. The memory changes only in that byte.
- R5: A halfword store drives `mem_be` = 4'b0011 when `acc_addr[1]`=0 and 4'b1100 when it is 1. It places `acc_wdata[15:0]` in that half.
- R6: A word access (`acc_size`=2'b10) uses `mem_be`=4'b1111. A store writes `acc_wdata` unchanged and a load returns `mem_rdata` unchanged.
- R7: A block transfer serves the set bits of `mt_list` from lowest to highest, one per cycle, starting in the cycle after `mt_start`. The k-th access drives `mt_reg_idx` = the index of that bit and `mem_addr` = (`mt_base` with bits [1:0] cleared) + 4·k.
- R8: A block load (`mt_is_store`=0) asserts `mt_reg_we` with `mt_load_data` = `mem_rdata` on every access. A block store drives `mem_we`=1, `mem_be`=4'b1111 and `mem_wdata` = `mt_reg_wdata`.
- R9: An empty `mt_list` causes no memory request. `mt_done` pulses in the cycle after `mt_start` and `mt_busy` stays low.
- R10: `mt_busy` is high exactly during the access cycles. `mt_done` is high for exactly one cycle, immediately after the last access, and never together with `mt_busy`.
- R11: While `mt_busy` is high, `acc_valid` has no effect on the memory port. A single store issued then leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Single access request |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word |
| acc_signed | input | 1 | Sign-extend sub-word loads |
| acc_addr | input | ADDR_W | Byte address of single access |
| acc_wdata | input | 32 | Store source value |
| ld_data | output | 32 | Extended load result |
| mt_start | input | 1 | Begin block transfer (accepted in idle) |
| mt_is_store | input | 1 | Block direction, 1 = store |
| mt_base | input | ADDR_W | Block base address |
| mt_list | input | NREGS | Register mask |
| mt_reg_idx | output | IDX_W | Register served this cycle |
| mt_reg_wdata | input | 32 | Register value for block stores |
| mt_reg_we | output | 1 | Write register with block load data |
| mt_load_data | output | 32 | Data for the register write |
| mt_busy | output | 1 | Block transfer access cycle |
| mt_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (same cycle) |

## Verification
The bench builds the unit with its defaults: a 32-bit address and a 16-entry register mask. It attaches a 16-word memory model and a 16-entry register model. With the full 16-bit mask, both the lowest (index 0) and the highest (index 15) register can appear in one transfer, together with gaps in the mask. The small memory window keeps every block address and every lane position within a few words. A stray single store is easy to spot there.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } xfer_size_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_XFER,
        SEQ_DONE
    } seq_state_e;
endpackage

// File: rtl/load_extract.sv
module load_extract
    import ldst_pkg::*;
(
    input  logic [WORD_W-1:0] rdata,
    input  logic [1:0]        lane_addr,
    input  logic [1:0]        size,
    input  logic              is_signed,
    output logic [WORD_W-1:0] result
);
    logic [7:0]  lane_byte [LANES];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_byte[g] = rdata[8*g +: 8];
        end
    endgenerate

    always_comb begin
        pick_b = lane_byte[lane_addr];
        pick_h = lane_addr[1] ? rdata[31:16] : rdata[15:0];
        case (xfer_size_e'(size))
            SZ_BYTE: result = {{(WORD_W-8){is_signed & pick_b[7]}}, pick_b};
            SZ_HALF: result = {{(WORD_W-16){is_signed & pick_h[15]}}, pick_h};
            default: result = rdata;
        endcase
    end

    always_comb begin
        if (is_signed && xfer_size_e'(size) == SZ_BYTE)
            assert_byte_sign_R3: assert (result[WORD_W-1:8] == {(WORD_W-8){rdata[8*lane_addr+7]}});
        if (!is_signed && xfer_size_e'(size) == SZ_HALF)
            assert_half_zero_R2: assert (result[WORD_W-1:16] == '0);
    end
endmodule

// File: rtl/store_place.sv
module store_place
    import ldst_pkg::*;
(
    input  logic [WORD_W-1:0] wdata,
    input  logic [1:0]        lane_addr,
    input  logic [1:0]        size,
    output logic [WORD_W-1:0] wdata_out,
    output logic [LANES-1:0]  be
);
    logic [LANES-1:0] byte_sel;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_sel
            assign byte_sel[g] = (lane_addr == 2'(g));
        end
    endgenerate

    always_comb begin
        case (xfer_size_e'(size))
            SZ_BYTE: begin
                be        = byte_sel;
                wdata_out = {LANES{wdata[7:0]}};
            end
            SZ_HALF: begin
                be        = lane_addr[1] ? 4'b1100 : 4'b0011;
                wdata_out = {2{wdata[15:0]}};
            end
            default: begin
                be        = '1;
                wdata_out = wdata;
            end
        endcase
    end

    always_comb begin
        if (xfer_size_e'(size) == SZ_BYTE)
            assert_byte_onehot_R4: assert ($countones(be) == 1);
        if (xfer_size_e'(size) == SZ_HALF)
            assert_half_pair_R5: assert (be == 4'b0011 || be == 4'b1100);
    end
endmodule

// File: rtl/block_seq.sv
module block_seq
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREGS  = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_store,
    input  logic [ADDR_W-1:0] base,
    input  logic [NREGS-1:0]  list,
    output logic              busy,
    output logic              done,
    output logic              seq_we,
    output logic              reg_we,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  reg_idx
);
    seq_state_e        state_q;
    logic [NREGS-1:0]  rem_q;
    logic [NREGS-1:0]  rem_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              dir_q;
    logic [IDX_W-1:0]  cur_idx;

    always_comb begin
        cur_idx = '0;
        for (int i = NREGS - 1; i >= 0; i--) begin
            if (rem_q[i]) cur_idx = IDX_W'(i);
        end
        rem_nxt = rem_q & (rem_q - NREGS'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            rem_q   <= '0;
            addr_q  <= '0;
            dir_q   <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        rem_q   <= list;
                        addr_q  <= base & ~ADDR_W'(3);
                        dir_q   <= is_store;
                        state_q <= (list == '0) ? SEQ_DONE : SEQ_XFER;
                    end
                end
                SEQ_XFER: begin
                    rem_q  <= rem_nxt;
                    addr_q <= addr_q + ADDR_W'(4);
                    if (rem_nxt == '0) state_q <= SEQ_DONE;
                end
                SEQ_DONE: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state_q == SEQ_XFER);
        done    = (state_q == SEQ_DONE);
        seq_we  = busy & dir_q;
        reg_we  = busy & ~dir_q;
        addr    = addr_q;
        reg_idx = cur_idx;
    end

    assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (addr == $past(addr) + ADDR_W'(4)));
    assert_empty_list_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && start && list == '0) |=> (done && !busy));
endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREGS  = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_is_store,
    input  logic [1:0]        acc_size,
    input  logic              acc_signed,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       ld_data,
    input  logic              mt_start,
    input  logic              mt_is_store,
    input  logic [ADDR_W-1:0] mt_base,
    input  logic [NREGS-1:0]  mt_list,
    output logic [IDX_W-1:0]  mt_reg_idx,
    input  logic [31:0]       mt_reg_wdata,
    output logic              mt_reg_we,
    output logic [31:0]       mt_load_data,
    output logic              mt_busy,
    output logic              mt_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    logic              seq_busy;
    logic              seq_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [31:0]       st_wdata;
    logic [3:0]        st_be;
    logic              single_go;

    load_extract u_ld (
        .rdata     (mem_rdata),
        .lane_addr (acc_addr[1:0]),
        .size      (acc_size),
        .is_signed (acc_signed),
        .result    (ld_data)
    );

    store_place u_st (
        .wdata     (acc_wdata),
        .lane_addr (acc_addr[1:0]),
        .size      (acc_size),
        .wdata_out (st_wdata),
        .be        (st_be)
    );

    block_seq #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (mt_start),
        .is_store (mt_is_store),
        .base     (mt_base),
        .list     (mt_list),
        .busy     (seq_busy),
        .done     (mt_done),
        .seq_we   (seq_we),
        .reg_we   (mt_reg_we),
        .addr     (seq_addr),
        .reg_idx  (mt_reg_idx)
    );

    always_comb begin
        single_go    = acc_valid & ~seq_busy;
        mt_busy      = seq_busy;
        mt_load_data = mem_rdata;
        if (seq_busy) begin
            mem_req   = 1'b1;
            mem_we    = seq_we;
            mem_addr  = seq_addr;
            mem_be    = 4'hF;
            mem_wdata = mt_reg_wdata;
        end else begin
            mem_req   = single_go;
            mem_we    = single_go & acc_is_store;
            mem_addr  = acc_addr;
            mem_be    = single_go ? st_be : 4'h0;
            mem_wdata = st_wdata;
        end
    end

    assert_busy_owns_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mt_busy |-> (mem_req && mem_be == 4'hF && mem_addr[1:0] == 2'b00));
    assert_done_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_done && !acc_valid) |-> !mem_req);
endmodule

// File: tb/ldst_lane_unit_test.sv
module ldst_lane_unit_test;
    localparam int AW = 32;
    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_is_store = 0, acc_signed = 0;
    logic [1:0]  acc_size = 0;
    logic [31:0] acc_addr = 0, acc_wdata = 0, ld_data;
    logic        mt_start = 0, mt_is_store = 0;
    logic [31:0] mt_base = 0;
    logic [15:0] mt_list = 0;
    logic [3:0]  mt_reg_idx;
    logic [31:0] mt_reg_wdata, mt_load_data;
    logic        mt_reg_we, mt_busy, mt_done;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mem [16];
    logic [31:0] rf  [16];
    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    assign mem_rdata    = mem[mem_addr[5:2]];
    assign mt_reg_wdata = rf[mt_reg_idx];

    always @(posedge clk) begin
        if (mem_req && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        if (mt_reg_we) rf[mt_reg_idx] <= mt_load_data;
    end

    ldst_lane_unit #(.ADDR_W(AW), .NREGS(NR)) uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        #1;
        chk(mt_busy == 0 && mt_done == 0, "R10 reset", {30'b0, mt_busy, mt_done}, 0);
        chk(mem_req == 0, "R11 reset idle port", {31'b0, mem_req}, 0);
    endtask

    task automatic t_load(input logic [31:0] a, input logic [1:0] sz, input bit sg,
                          input logic [31:0] exp, input string req);
        @(negedge clk);
        acc_valid = 1; acc_is_store = 0; acc_addr = a; acc_size = sz; acc_signed = sg;
        #1;
        chk(ld_data == exp, req, ld_data, exp);
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic t_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd,
                           input logic [3:0] exp_be, input logic [31:0] exp_word, input string req);
        @(negedge clk);
        mem[a[5:2]] = 32'h0;
        acc_valid = 1; acc_is_store = 1; acc_addr = a; acc_size = sz; acc_wdata = wd;
        #1;
        chk(mem_be == exp_be, req, {28'b0, mem_be}, {28'b0, exp_be});
        @(negedge clk);
        acc_valid = 0; acc_is_store = 0;
        #1;
        chk(mem[a[5:2]] == exp_word, req, mem[a[5:2]], exp_word);
    endtask

    task automatic t_block(input bit st, input logic [31:0] base, input logic [15:0] lst,
                           input bit interfere);
        int idxs[$];
        for (int i = 0; i < 16; i++) if (lst[i]) idxs.push_back(i);
        @(negedge clk);
        mt_start = 1; mt_is_store = st; mt_base = base; mt_list = lst;
        #1;
        chk(mem_req == 0, "R9 no access in start cycle", {31'b0, mem_req}, 0);
        @(negedge clk);
        mt_start = 0;
        foreach (idxs[k]) begin
            acc_valid = interfere; acc_is_store = 1; acc_size = 2'b10;
            acc_addr = 32'h3C; acc_wdata = 32'hFFFF_FFFF;
            #1;
            chk(mt_busy && mem_req, "R10 busy during access", {30'b0, mt_busy, mem_req}, 3);
            chk(mem_addr == (base & ~32'h3) + 4 * k, "R7 address", mem_addr, (base & ~32'h3) + 4 * k);
            chk(mt_reg_idx == 4'(idxs[k]), "R7 register order", {28'b0, mt_reg_idx}, idxs[k]);
            chk(mem_we == st && mt_reg_we == !st, "R8 direction",
                {30'b0, mem_we, mt_reg_we}, {30'b0, st, !st});
            if (st) chk(mem_wdata == rf[idxs[k]] && mem_be == 4'hF, "R8 store data", mem_wdata, rf[idxs[k]]);
            @(negedge clk);
        end
        acc_valid = 0; acc_is_store = 0;
        #1;
        chk(mt_done && !mt_busy && !mem_req, "R10 done after last access",
            {29'b0, mt_done, mt_busy, mem_req}, 32'h4);
        @(negedge clk);
        #1;
        chk(!mt_done, "R10 done lasts one cycle", {31'b0, mt_done}, 0);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mem[i] = 32'h0; rf[i] = 32'h0; end
        #5 rst_n = 1;
        t_reset();
        mem[8] = 32'h8A7F_C312;
        t_load(32'h20, 2'b00, 0, 32'h0000_0012, "R1 byte lane0");
        t_load(32'h21, 2'b00, 0, 32'h0000_00C3, "R1 byte lane1");
        t_load(32'h23, 2'b00, 0, 32'h0000_008A, "R1 byte lane3");
        t_load(32'h20, 2'b01, 0, 32'h0000_C312, "R2 half low");
        t_load(32'h22, 2'b01, 0, 32'h0000_8A7F, "R2 half high");
        t_load(32'h21, 2'b00, 1, 32'hFFFF_FFC3, "R3 signed byte negative");
        t_load(32'h22, 2'b00, 1, 32'h0000_007F, "R3 signed byte positive");
        t_load(32'h22, 2'b01, 1, 32'hFFFF_8A7F, "R3 signed half high");
        t_load(32'h20, 2'b01, 1, 32'hFFFF_C312, "R3 signed half low");
        t_load(32'h20, 2'b10, 1, 32'h8A7F_C312, "R6 word load");
        t_store(32'h25, 2'b00, 32'hDEAD_BEEF, 4'b0010, 32'h0000_EF00, "R4 byte store lane1");
        t_store(32'h27, 2'b00, 32'h1234_5678, 4'b1000, 32'h7800_0000, "R4 byte store lane3");
        t_store(32'h2A, 2'b01, 32'hDEAD_BEEF, 4'b1100, 32'hBEEF_0000, "R5 half store high");
        t_store(32'h28, 2'b01, 32'hCAFE_F00D, 4'b0011, 32'h0000_F00D, "R5 half store low");
        t_store(32'h2C, 2'b10, 32'hDEAD_BEEF, 4'b1111, 32'hDEAD_BEEF, "R6 word store");

        mem[4] = 32'h1111_1111; mem[5] = 32'h2222_2222;
        mem[6] = 32'h3333_3333; mem[7] = 32'h4444_4444;
        t_block(0, 32'h12, 16'b1000_0100_0010_0001, 0);
        chk(rf[0] == 32'h1111_1111, "R8 load reg0", rf[0], 32'h1111_1111);
        chk(rf[5] == 32'h2222_2222, "R8 load reg5", rf[5], 32'h2222_2222);
        chk(rf[10] == 32'h3333_3333, "R8 load reg10", rf[10], 32'h3333_3333);
        chk(rf[15] == 32'h4444_4444, "R8 load reg15", rf[15], 32'h4444_4444);

        rf[1] = 32'hA1A1_A1A1; rf[2] = 32'hB2B2_B2B2; rf[3] = 32'hC3C3_C3C3;
        mem[15] = 32'h0;
        t_block(1, 32'h30, 16'h000E, 1);
        chk(mem[12] == 32'hA1A1_A1A1, "R8 store word 0", mem[12], 32'hA1A1_A1A1);
        chk(mem[13] == 32'hB2B2_B2B2, "R8 store word 1", mem[13], 32'hB2B2_B2B2);
        chk(mem[14] == 32'hC3C3_C3C3, "R8 store word 2", mem[14], 32'hC3C3_C3C3);
        chk(mem[15] == 32'h0, "R11 single store ignored while busy", mem[15], 32'h0);

        @(negedge clk);
        mt_start = 1; mt_list = 16'h0; mt_base = 32'h10;
        #1;
        chk(mem_req == 0, "R9 empty start cycle", {31'b0, mem_req}, 0);
        @(negedge clk);
        mt_start = 0;
        #1;
        chk(mt_done && !mt_busy && !mem_req, "R9 empty list completes",
            {29'b0, mt_done, mt_busy, mem_req}, 32'h4);
        @(negedge clk);
        #1;
        chk(!mt_done && !mt_busy, "R9 empty done one cycle", {30'b0, mt_done, mt_busy}, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule